// File: doc/BRIEF.md
# Scripted Serial Frame Executor

This block runs a small command program and turns it into a single-wire bitstream, one bit per clock. Each 16-bit command word asks for one kind of output: a run of alternating fill, a start marker, a data field of 1 to 8 bits, a 4-bit check code over the data sent since the last start marker, or a two-bit trigger pattern. A line-valid qualifier runs beside the bit line, so a receiver can tell emitted bits from the single dead clocks that skipped words leave behind.

There are two command banks. While one bank runs, the host refills the other through a plain write port. An end command parks the executor, which then sends alternating fill until the external time tick arrives. On that tick it moves to address 0 of the other bank and pulses an interrupt, so the host knows which bank has just gone idle. A trigger placed first in a script therefore goes out on the two clocks right after the tick.

Top module: `frame_script_exec`

## Requirements
- R1: While reset is held, `ser_vld`, `ser_bit` and `irq` are 0. After reset, execution starts at address 0 of bank 0.
- R2: The opcode is word bits [15:11]. When bit 15 is 0 and the opcode is 00000 or any value above 00101, the word takes one clock with `ser_vld` low and emits no bit.
- R3: Opcode 00001 emits 1, 0, 0 on three consecutive clocks and clears the check-code register.
- R4: Opcode 00010 emits code+1 bits, where code is bits [10:8], taken from bits [7:0] starting at bit `code` and going down to bit 0. The first bit of every command follows the previous command's last bit on the very next clock.
- R5: Opcode 00011 emits 4 bits, most significant first. They are the remainder of (data bits since the last start marker)·x^4 divided by x^4+x+1.
- R6: A word with bit 15 set emits 2·(count+1) alternating bits starting with 1, where count is bits [14:0].
- R7: Opcode 00100 emits 1 on its own clock, then alternating bits starting with 0 on every clock. This continues up to and including the clock on which `tick` is sampled high. The next clock executes address 0 of the other bank.
- R8: `irq` is high for exactly one clock: the clock after the tick that ends a wait.
- R9: `tick` outside a wait has no effect. The stream continues unchanged and `irq` stays low.
- R10: Opcode 00101 emits 1, 1 on two consecutive clocks.
- R11: Writes go to any address of either bank at any time. A script written into the idle bank during a wait runs after the swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Command write strobe |
| wr_bank | input | 1 | Bank selected for the write |
| wr_addr | input | ADDR_W | Word address within the bank |
| wr_data | input | 16 | Command word |
| tick | input | 1 | Time tick that releases a wait |
| ser_bit | output | 1 | Serial output bit |
| ser_vld | output | 1 | High when ser_bit carries an emitted bit |
| irq | output | 1 | One-clock pulse on each bank swap |

## Verification
The hardest situation to reach from the ports is a script that the host rewrites into the idle bank while the executor waits on the other bank. That script must then start on the first clock after the tick. The stimulus gets there by running bank 0, then bank 1, then holding in the second wait while it writes a new program into bank 0, and only then raising the tick. In that last swap the tick is held for two clocks, so the second tick clock lands while the new script is already executing. A separate tick pulse placed in the middle of a long fill run shows that a stray tick changes nothing. The scripts also cover a one-bit data field just before a check code, and skipped words placed between commands.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
   localparam int WORD_W  = 16;
   localparam int OP_W    = 5;
   localparam int FIELD_W = 8;
   localparam int CODE_W  = 3;
   localparam int CRC_W   = 4;
   localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

   typedef enum logic [OP_W-1:0] {
      OP_NULL  = 5'd0,
      OP_START = 5'd1,
      OP_DATA  = 5'd2,
      OP_CRC   = 5'd3,
      OP_END   = 5'd4,
      OP_TRIG  = 5'd5
   } op_e;

   typedef enum logic [1:0] {
      MD_FETCH,
      MD_SHIFT,
      MD_PRE,
      MD_WAIT
   } mode_e;
endpackage

// File: rtl/sfx_script_ram.sv
module sfx_script_ram #(
   parameter int ADDR_W = 4,
   parameter int WORD_W = 16,
   parameter int BANKS  = 2
) (
   input  logic                      clk,
   input  logic                      wr_en,
   input  logic [$clog2(BANKS)-1:0]  wr_bank,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [WORD_W-1:0]         wr_data,
   input  logic [$clog2(BANKS)-1:0]  rd_bank,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [WORD_W-1:0]         rd_data
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int BANK_W = $clog2(BANKS);

   if (BANKS < 2 || (BANKS & (BANKS - 1)) != 0) begin : g_bad_banks
      $error("sfx_script_ram: BANKS must be a power of two of at least 2");
   end

   logic [WORD_W-1:0] bank_rd [BANKS];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic [WORD_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (wr_en && wr_bank == BANK_W'(b))
            mem[wr_addr] <= wr_data;
      end
      assign bank_rd[b] = mem[rd_addr];
   end

   assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/sfx_crc_serial.sv
module sfx_crc_serial #(
   parameter int           W    = 4,
   parameter logic [W-1:0] POLY = 4'b0011
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc
);
   if (W < 2) begin : g_bad_w
      $error("sfx_crc_serial: W must be at least 2");
   end

   logic fb;
   assign fb = crc[W-1] ^ din;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         crc <= '0;
      else if (clr)
         crc <= '0;
      else if (en)
         crc <= {crc[W-2:0], 1'b0} ^ (fb ? POLY : '0);
   end

   // R3
   crc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !en) |=> (crc == '0));
endmodule

// File: rtl/frame_script_exec.sv
module frame_script_exec
   import sfx_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_bank,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              tick,
   output logic              ser_bit,
   output logic              ser_vld,
   output logic              irq
);
   localparam int CNT_W = WORD_W;
   localparam int SH_W  = $clog2(FIELD_W) + 1;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("frame_script_exec: ADDR_W out of range");
   end
   if (CRC_W > FIELD_W) begin : g_bad_crc
      $error("frame_script_exec: check code wider than pattern register");
   end

   mode_e               mode;
   logic                bank;
   logic [ADDR_W-1:0]   pc;
   logic [FIELD_W-1:0]  pat;
   logic [CNT_W-1:0]    rem;
   logic                ph;
   logic                crc_on;
   logic [WORD_W-1:0]   word;
   logic [CRC_W-1:0]    crc;
   logic                crc_clr, crc_en, crc_din;

   sfx_script_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BANKS(2)) u_ram (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_bank (wr_bank),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_bank (bank),
      .rd_addr (pc),
      .rd_data (word)
   );

   sfx_crc_serial #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (crc_clr),
      .en    (crc_en),
      .din   (crc_din),
      .crc   (crc)
   );

   // command word fields
   logic                is_rep;
   op_e                 op;
   logic [CODE_W-1:0]   code;
   logic [FIELD_W-1:0]  fld;
   logic [SH_W-1:0]     sh_amt;
   logic [2*FIELD_W-1:0] fld_sh;

   assign is_rep = word[WORD_W-1];
   assign op     = op_e'(word[WORD_W-1 -: OP_W]);
   assign code   = word[FIELD_W +: CODE_W];
   assign fld    = word[FIELD_W-1:0];
   assign sh_amt = SH_W'(FIELD_W) - SH_W'(code);
   assign fld_sh = {{FIELD_W{1'b0}}, fld} << sh_amt;

   always_comb begin
      crc_clr = 1'b0;
      crc_en  = 1'b0;
      crc_din = 1'b0;
      if (mode == MD_FETCH && !is_rep) begin
         if (op == OP_START) begin
            crc_clr = 1'b1;
         end else if (op == OP_DATA) begin
            crc_en  = 1'b1;
            crc_din = fld[code];
         end
      end else if (mode == MD_SHIFT && crc_on) begin
         crc_en  = 1'b1;
         crc_din = pat[FIELD_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode    <= MD_FETCH;
         bank    <= 1'b0;
         pc      <= '0;
         pat     <= '0;
         rem     <= '0;
         ph      <= 1'b0;
         crc_on  <= 1'b0;
         ser_bit <= 1'b0;
         ser_vld <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= 1'b0;
         case (mode)
            MD_FETCH: begin
               pc      <= pc + ADDR_W'(1);
               ser_vld <= 1'b1;
               ser_bit <= 1'b1;
               if (is_rep) begin
                  rem  <= {word[WORD_W-2:0], 1'b1};
                  ph   <= 1'b0;
                  mode <= MD_PRE;
               end else begin
                  case (op)
                     OP_START: begin
                        pat    <= '0;
                        rem    <= CNT_W'(2);
                        crc_on <= 1'b0;
                        mode   <= MD_SHIFT;
                     end
                     OP_DATA: begin
                        ser_bit <= fld[code];
                        pat     <= fld_sh[FIELD_W-1:0];
                        rem     <= CNT_W'(code);
                        crc_on  <= 1'b1;
                        mode    <= (code == '0) ? MD_FETCH : MD_SHIFT;
                     end
                     OP_CRC: begin
                        ser_bit <= crc[CRC_W-1];
                        pat     <= {crc[CRC_W-2:0], {(FIELD_W-CRC_W+1){1'b0}}};
                        rem     <= CNT_W'(CRC_W-1);
                        crc_on  <= 1'b0;
                        mode    <= MD_SHIFT;
                     end
                     OP_TRIG: begin
                        pat    <= {1'b1, {(FIELD_W-1){1'b0}}};
                        rem    <= CNT_W'(1);
                        crc_on <= 1'b0;
                        mode   <= MD_SHIFT;
                     end
                     OP_END: begin
                        ph   <= 1'b0;
                        mode <= MD_WAIT;
                     end
                     default: begin
                        ser_vld <= 1'b0;
                        ser_bit <= 1'b0;
                     end
                  endcase
               end
            end
            MD_SHIFT: begin
               ser_vld <= 1'b1;
               ser_bit <= pat[FIELD_W-1];
               pat     <= pat << 1;
               rem     <= rem - CNT_W'(1);
               if (rem == CNT_W'(1)) mode <= MD_FETCH;
            end
            MD_PRE: begin
               ser_vld <= 1'b1;
               ser_bit <= ph;
               ph      <= ~ph;
               rem     <= rem - CNT_W'(1);
               if (rem == CNT_W'(1)) mode <= MD_FETCH;
            end
            MD_WAIT: begin
               ser_vld <= 1'b1;
               ser_bit <= ph;
               ph      <= ~ph;
               if (tick) begin
                  bank <= ~bank;
                  pc   <= '0;
                  irq  <= 1'b1;
                  mode <= MD_FETCH;
               end
            end
            default: mode <= MD_FETCH;
         endcase
      end
   end

   // R8
   irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R8
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(tick));

   // R6
   pre_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PRE) |=> (ser_bit != $past(ser_bit)));

   // R7
   wait_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_WAIT) |=> ser_vld);

   // R9
   tick_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode != MD_WAIT) |=> !irq);
endmodule

// File: tb/tb_frame_script_exec.sv
module tb_frame_script_exec;
   localparam int AW = 4;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_bank = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [15:0]   wr_data = '0;
   logic          tick = 1'b0;
   logic          ser_bit, ser_vld, irq;

   always #2 clk = ~clk;

   frame_script_exec #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
      .wr_addr(wr_addr), .wr_data(wr_data), .tick(tick),
      .ser_bit(ser_bit), .ser_vld(ser_vld), .irq(irq)
   );

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   // reference model state
   logic [15:0] m_scr [0:1][0:DEPTH-1];
   logic [1:0]  q_e[$];
   string       q_t[$];
   int          dbits[$];
   bit          m_live = 0, m_wait = 0, m_bank = 0, m_ph = 0, m_first = 1;
   int          m_pc = 0;
   bit          refilled = 0;
   string       m_ov = "";
   bit          e_vld = 0, e_bit = 0, e_irq = 0;
   string       e_tag = "R1", e_itag = "R8";

   function automatic int crc_of();
      int r = 0;
      foreach (dbits[i]) begin
         r = (r << 1) | dbits[i];
         if ((r & 16) != 0) r = r ^ 19;
      end
      for (int k = 0; k < 4; k++) begin
         r = r << 1;
         if ((r & 16) != 0) r = r ^ 19;
      end
      return r;
   endfunction

   function automatic void push(bit v, bit b, string t);
      q_e.push_back({v, b});
      q_t.push_back((m_ov != "") ? m_ov : t);
   endfunction

   function automatic void expand(logic [15:0] w);
      m_ov = m_first ? "R1" : ((refilled && m_bank == 0) ? "R11" : "");
      m_first = 0;
      if (w[15]) begin
         for (int i = 0; i < 2 * (int'(w[14:0]) + 1); i++) push(1'b1, (i % 2) == 0, "R6");
      end else begin
         case (w[15:11])
            5'd1: begin
               push(1'b1, 1'b1, "R3"); push(1'b1, 1'b0, "R3"); push(1'b1, 1'b0, "R3");
               dbits.delete();
            end
            5'd2: begin
               for (int i = int'(w[10:8]); i >= 0; i--) begin
                  push(1'b1, w[i], "R4");
                  dbits.push_back(int'(w[i]));
               end
            end
            5'd3: begin
               int r;
               r = crc_of();
               for (int i = 3; i >= 0; i--) push(1'b1, r[i], "R5");
            end
            5'd4: begin
               push(1'b1, 1'b1, "R7");
               m_wait = 1;
               m_ph = 0;
            end
            5'd5: begin
               push(1'b1, 1'b1, "R10"); push(1'b1, 1'b1, "R10");
            end
            default: push(1'b0, 1'b0, "R2");
         endcase
      end
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_live = 0; m_wait = 0; m_bank = 0; m_pc = 0; m_first = 1;
         q_e.delete(); q_t.delete(); dbits.delete();
         e_vld = 0; e_bit = 0; e_irq = 0;
      end else begin
         m_live = 1;
         e_irq = 0;
         e_itag = tick ? "R9" : "R8";
         if (q_e.size() == 0 && m_wait) begin
            e_vld = 1; e_bit = m_ph; e_tag = "R7";
            m_ph = ~m_ph;
            if (tick) begin
               m_bank = ~m_bank; m_pc = 0; m_wait = 0;
               e_irq = 1; e_itag = "R8";
            end
         end else begin
            if (q_e.size() == 0) begin
               expand(m_scr[m_bank][m_pc]);
               m_pc = (m_pc + 1) % DEPTH;
            end
            {e_vld, e_bit} = q_e.pop_front();
            e_tag = q_t.pop_front();
         end
      end
   end

   task automatic check(logic act, logic exp, string tag, string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && m_live) begin
         check(ser_vld, e_vld, e_tag, "ser_vld");
         if (e_vld) check(ser_bit, e_bit, e_tag, "ser_bit");
         check(irq, e_irq, e_itag, "irq");
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   task automatic put(bit b, int a, logic [15:0] w);
      @(negedge clk);
      wr_en = 1'b1; wr_bank = b; wr_addr = a[AW-1:0]; wr_data = w;
      m_scr[b][a] = w;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [15:0] w_data(int code, int val);
      return {5'd2, 3'(code), 8'(val)};
   endfunction

   function automatic logic [15:0] w_nop(int cnt);
      return {1'b1, 15'(cnt)};
   endfunction

   localparam logic [15:0] W_START = 16'h0800;
   localparam logic [15:0] W_CRC   = 16'h1800;
   localparam logic [15:0] W_END   = 16'h2000;
   localparam logic [15:0] W_TRIG  = 16'h2800;

   initial begin
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < DEPTH; a++) m_scr[b][a] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(ser_vld, 1'b0, "R1", "ser_vld in reset");
      check(ser_bit, 1'b0, "R1", "ser_bit in reset");
      check(irq, 1'b0, "R1", "irq in reset");

      // bank 0: fill, skips, one frame with four fields and its code
      put(0, 0, w_nop(2));
      put(0, 1, 16'h0000);
      put(0, 2, W_START);
      put(0, 3, w_data(7, 8'hA5));
      put(0, 4, w_data(4, 8'h13));
      put(0, 5, w_data(2, 8'h06));
      put(0, 6, w_data(3, 8'h09));
      put(0, 7, W_CRC);
      put(0, 8, 16'h3000);
      put(0, 9, w_nop(1));
      put(0, 10, W_END);
      // bank 1: trigger first, one-bit field, long fill for a stray tick
      put(1, 0, W_TRIG);
      put(1, 1, w_nop(0));
      put(1, 2, W_START);
      put(1, 3, w_data(0, 8'h01));
      put(1, 4, w_data(7, 8'hFF));
      put(1, 5, W_CRC);
      put(1, 6, 16'h7800);
      put(1, 7, w_nop(20));
      put(1, 8, W_END);

      @(negedge clk);
      rst_n = 1'b1;

      while (!m_wait) @(negedge clk);
      repeat (5) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;

      // R9: stray tick in the middle of the long fill run of bank 1
      repeat (35) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;

      while (!m_wait) @(negedge clk);
      // R11: refill the idle bank while waiting
      put(0, 0, W_TRIG);
      put(0, 1, W_START);
      put(0, 2, w_data(7, 8'h00));
      put(0, 3, W_CRC);
      put(0, 4, W_START);
      put(0, 5, w_data(7, 8'h3C));
      put(0, 6, w_data(1, 8'h02));
      put(0, 7, W_CRC);
      put(0, 8, W_END);
      refilled = 1;
      @(negedge clk);
      tick = 1'b1;
      repeat (2) @(negedge clk);
      tick = 1'b0;

      while (!m_wait) @(negedge clk);
      repeat (6) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule